// File: doc/BRIEF.md
# Infrared Mark/Space Interval Timer

This block times the alternating mark and space intervals on a demodulated infrared receiver line. The receiver idles high and pulls low while a carrier burst is present, so a low line is a mark and a high line is a space. The line is brought into the clock domain through a two-stage synchronizer. A microsecond time base is derived from the core clock by a programmable divider, and it drives a saturating interval counter.

Each completed interval produces one single-cycle strobe with a level flag and a duration. The level flag is inverted with respect to the line: a mark is reported as 1 and a space as 0. A rising line edge ends a mark, restarts the interval counter and restarts the divider phase. A falling edge ends a space, reports the running count and stores it. The mark length is then the count at the next rising edge minus that stored value. A programmable timeout fires a single-cycle pulse once per counter period, when the count reaches the programmed value while the line sits idle-high. Firmware uses the timeout to detect the end of a frame.

Top module: `ir_pulse_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cap_valid`, `cap_level`, `cap_duration` and `timeout_pulse` are all zero.
- R2: A high-to-low line transition (end of a space) produces a strobe with `cap_level` = 0 and `cap_duration` equal to the interval count at that edge. That count is stored, and the counter keeps running.
- R3: A low-to-high line transition (end of a mark) produces a strobe with `cap_level` = 1 and `cap_duration` equal to the interval count minus the count stored at the last falling edge. The interval counter and the divider phase then restart from zero.
- R4: The interval counter advances once every `ticks_per_us` clock cycles (a value of 0 acts as 1). An edge seen k cycles after the restart point reports floor((k-1)/`ticks_per_us`).
- R5: The interval counter stops at `CNT_MAX` and never exceeds it. Durations saturate at that value.
- R6: When the counter equals `timeout_us` and the synchronized line is high, `timeout_pulse` is high for exactly one cycle.
- R7: When the counter equals `timeout_us` while the line is low (mark in progress), no timeout pulse is produced for that period.
- R8: At most one timeout pulse occurs per counter period. A counter held at a saturated value equal to `timeout_us` does not retrigger it.
- R9: While `enable` is low, no strobe or timeout pulse is produced, and the counter and stored falling-edge count are held at zero. Counting resumes from zero when `enable` returns high.
- R10: A strobe appears in the third clock cycle after the cycle in which the line changed, which is the latency of the two synchronizer stages plus the edge detection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low holds the counters at zero and silences outputs |
| ir_pin | input | 1 | Raw demodulated receiver line, active low |
| ticks_per_us | input | PRE_W | Clock cycles per microsecond tick |
| timeout_us | input | 32 | Idle timeout in microsecond ticks |
| cap_valid | output | 1 | One-cycle strobe: an interval has completed |
| cap_level | output | 1 | 1 for a mark, 0 for a space |
| cap_duration | output | 32 | Length of the completed interval in ticks |
| timeout_pulse | output | 1 | One-cycle idle timeout pulse |

## Verification
The hardest situation to reach from the ports is a counter that sits saturated at a value equal to the programmed timeout for hundreds of cycles. In that state a naive comparator would pulse again on every cycle. The bench runs with a small `CNT_MAX` override and a divider of 4, holds the line high well past saturation, and confirms that exactly one pulse arrives in the predicted cycle. A second hard case is a timeout match that falls inside a mark, which must disarm the period silently. The bench chooses a mark length that places the match a few cycles before the rising edge and checks that nothing is reported.

// File: rtl/irc_pkg.sv
package irc_pkg;
    localparam int DUR_W = 32;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } irc_edge_e;

    typedef struct packed {
        logic             level;
        logic [DUR_W-1:0] duration;
    } irc_capture_t;

    // Saturating increment toward an upper limit
    function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v,
                                                 input logic [DUR_W-1:0] lim);
        return (v < lim) ? v + 1'b1 : v;
    endfunction
endpackage

// File: rtl/irc_sync.sv
module irc_sync
    import irc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output logic      level,
    output irc_edge_e edge_kind
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{1'b1}};
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];

    always_comb begin
        if (level && !prev_q)      edge_kind = EDGE_RISE;
        else if (!level && prev_q) edge_kind = EDGE_FALL;
        else                       edge_kind = EDGE_NONE;
    end
endmodule

// File: rtl/irc_tick.sv
module irc_tick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] ticks_per_us,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] last;

    assign last = (ticks_per_us == '0) ? '0 : ticks_per_us - 1'b1;
    assign tick = run && (div_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) div_q <= '0;
        else if (div_q == last)     div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/irc_counter.sv
module irc_counter
    import irc_pkg::*;
#(
    parameter logic [DUR_W-1:0] CNT_MAX = 32'h7FFF_FFFE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    output logic [DUR_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || !run)  count <= '0;
        else if (restart) count <= '0;
        else if (tick)    count <= sat_inc(count, CNT_MAX);
    end
endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
    import irc_pkg::*;
#(
    parameter int               PRE_W   = 8,
    parameter int               SYNC_N  = 2,
    parameter logic [DUR_W-1:0] CNT_MAX = 32'h7FFF_FFFE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             ir_pin,
    input  logic [PRE_W-1:0] ticks_per_us,
    input  logic [DUR_W-1:0] timeout_us,
    output logic             cap_valid,
    output logic             cap_level,
    output logic [DUR_W-1:0] cap_duration,
    output logic             timeout_pulse
);
    logic             line_lvl;
    irc_edge_e        edge_kind;
    logic             rise_evt, fall_evt;
    logic             tick;
    logic [DUR_W-1:0] count_q;
    logic [DUR_W-1:0] fall_q;
    logic             armed_q;
    logic             match;
    irc_capture_t     cap_d, cap_q;
    logic             valid_q;

    irc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .pin(ir_pin),
        .level(line_lvl), .edge_kind(edge_kind)
    );

    assign rise_evt = enable && (edge_kind == EDGE_RISE);
    assign fall_evt = enable && (edge_kind == EDGE_FALL);

    irc_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .run(enable), .restart(rise_evt),
        .ticks_per_us(ticks_per_us), .tick(tick)
    );

    irc_counter #(.CNT_MAX(CNT_MAX)) u_cnt (
        .clk(clk), .rst(rst), .run(enable), .restart(rise_evt),
        .tick(tick), .count(count_q)
    );

    // Falling-edge count is the reference for the following mark
    always_ff @(posedge clk) begin
        if (rst || !enable) fall_q <= '0;
        else if (fall_evt)  fall_q <= count_q;
    end

    always_comb begin
        cap_d.level    = rise_evt;
        cap_d.duration = rise_evt ? count_q - fall_q : count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cap_q   <= '0;
        end else begin
            valid_q <= rise_evt || fall_evt;
            if (rise_evt || fall_evt) cap_q <= cap_d;
        end
    end

    // Timeout: one chance per counter period, only when the line idles high
    assign match = (count_q == timeout_us);

    always_ff @(posedge clk) begin
        if (rst || !enable) armed_q <= 1'b1;
        else if (rise_evt)  armed_q <= 1'b1;
        else if (match)     armed_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) timeout_pulse <= 1'b0;
        else     timeout_pulse <= enable && match && armed_q && line_lvl && !rise_evt;
    end

    assign cap_valid    = valid_q;
    assign cap_level    = cap_q.level;
    assign cap_duration = cap_q.duration;
endmodule

// File: rtl/irc_checker.sv
module irc_checker
    import irc_pkg::*;
#(
    parameter logic [DUR_W-1:0] CNT_MAX = 32'h7FFF_FFFE
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             cap_valid,
    input logic             cap_level,
    input logic [DUR_W-1:0] cap_duration,
    input logic             timeout_pulse,
    input logic [DUR_W-1:0] count_q
);
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_MAX);

    assert_dur_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> cap_duration <= CNT_MAX);

    assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && cap_level) |-> count_q == '0);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse);

    assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!cap_valid && !timeout_pulse && count_q == '0));
endmodule

bind ir_pulse_capture irc_checker #(.CNT_MAX(CNT_MAX)) u_chk (
    .clk(clk), .rst(rst), .enable(enable),
    .cap_valid(cap_valid), .cap_level(cap_level), .cap_duration(cap_duration),
    .timeout_pulse(timeout_pulse), .count_q(count_q)
);

// File: tb/ir_pulse_capture_test.sv
`timescale 1ns/1ps
module ir_pulse_capture_test;
    localparam int MAXV = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        ir_pin = 1'b1;
    logic [7:0]  ticks_per_us = 8'd4;
    logic [31:0] timeout_us = 32'd20;
    logic        cap_valid, cap_level, timeout_pulse;
    logic [31:0] cap_duration;

    ir_pulse_capture #(.PRE_W(8), .SYNC_N(2), .CNT_MAX(32'd200)) uut (
        .clk(clk), .rst(rst), .enable(enable), .ir_pin(ir_pin),
        .ticks_per_us(ticks_per_us), .timeout_us(timeout_us),
        .cap_valid(cap_valid), .cap_level(cap_level),
        .cap_duration(cap_duration), .timeout_pulse(timeout_pulse)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit    is_to;
        bit    level;
        int    dur;
        int    cyc;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    int   disabled_hits = 0;

    // Bench model state
    int ref_cyc, saved, tmo_val, nper;
    bit armed;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cnt_at(input int k);
        int v;
        v = (k - 1) / nper;
        if (v > MAXV) v = MAXV;
        return v;
    endfunction

    // Driver: set the line, predict results, hold for c cycles
    task automatic drive(input bit lvl, input int c);
        int y, k, v, m;
        exp_t e;
        y = cyc;
        if (lvl != ir_pin) begin
            ir_pin = lvl;
            k = y - ref_cyc;
            v = cnt_at(k);
            e.is_to = 0; e.cyc = y + 3; e.level = lvl;
            if (!lvl) begin
                e.dur = v; e.req = "R2"; saved = v;
            end else begin
                e.dur = v - saved; e.req = "R3"; ref_cyc = y; armed = 1;
            end
            exp_q.push_back(e);
        end
        if (armed && tmo_val <= MAXV) begin
            m = ref_cyc + tmo_val * nper + 4;
            if (m >= y + 3 && m <= y + c + 2) begin
                armed = 0;
                if (lvl) begin
                    e.is_to = 1; e.level = 0; e.dur = 0; e.cyc = m; e.req = "R6";
                    exp_q.push_back(e);
                end
            end
        end
        repeat (c) begin @(posedge clk); #1; end
    endtask

    task automatic start_run();
        @(posedge clk); #1;
        enable = 1'b1;
        ref_cyc = cyc - 3; saved = 0; armed = 1;
        nper = (ticks_per_us == 0) ? 1 : int'(ticks_per_us);
        tmo_val = int'(timeout_us);
    endtask

    // Monitor: pop and compare as results appear
    task automatic compare(input bit is_to);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(0, enable ? "R8" : "R9", "unexpected output", 1, 0);
            if (!enable) disabled_hits++;
            return;
        end
        e = exp_q.pop_front();
        check(e.is_to == is_to, e.req, "event kind", int'(is_to), int'(e.is_to));
        if (!is_to) begin
            check(cap_level == e.level, e.req, "level", int'(cap_level), int'(e.level));
            check(int'(cap_duration) == e.dur, e.req, "duration", int'(cap_duration), e.dur);
            check(cyc == e.cyc, "R10", "strobe cycle", cyc, e.cyc);
        end else begin
            check(cyc == e.cyc, "R6", "timeout cycle", cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (cap_valid) compare(0);
            if (timeout_pulse) compare(1);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(cap_valid == 0 && timeout_pulse == 0 && cap_level == 0 && cap_duration == 0,
              "R1", "outputs in reset", int'(cap_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(cap_valid == 0 && timeout_pulse == 0 && cap_duration == 0,
              "R1", "outputs after reset", int'(cap_valid), 0);

        // Divider of 4, timeout 20 ticks
        start_run();
        drive(1, 30);    // idle high, short
        drive(0, 50);    // space ends (R2); mark long enough for a match inside it (R7)
        drive(1, 200);   // mark ends (R3); idle past timeout (R6)
        drive(0, 10);
        drive(1, 900);   // timeout once, then saturate (R5, R8)
        drive(0, 10);    // space saturated at MAXV (R5)
        timeout_us = 32'd200; tmo_val = 200;
        drive(1, 1000);  // mark reads 0 after saturation; match held at max (R8)
        drive(0, 10);

        // Disable: line activity must be ignored (R9)
        enable = 1'b0;
        repeat (4) begin @(posedge clk); #1; end
        ir_pin = 1'b1; repeat (5) begin @(posedge clk); #1; end
        ir_pin = 1'b0; repeat (5) begin @(posedge clk); #1; end
        ir_pin = 1'b1; repeat (10) begin @(posedge clk); #1; end
        check(disabled_hits == 0, "R9", "strobes while disabled", disabled_hits, 0);

        // Re-enable with divider 1: counting restarts from zero (R9, R4)
        ticks_per_us = 8'd1;
        timeout_us   = 32'd20;
        start_run();
        drive(1, 10);
        drive(0, 40);    // match during mark, suppressed (R7)
        drive(1, 60);    // timeout at 20 ticks (R6)
        drive(0, 20);
        drive(1, 30);

        repeat (10) begin @(posedge clk); #1; end
        check(exp_q.size() == 0, "R6", "expected events left", exp_q.size(), 0);
        finish_run();
    end
endmodule